// File: doc/BRIEF.md
# Recursive Crosswise Array Multiplier

This block multiplies two 16-bit unsigned numbers and returns the full 32-bit product in the same cycle. It holds no state. Software-visible timing is set only by the enclosing pipeline.

The product is built by recursion. Each level splits both operands into a high half and a low half. It forms the four cross products (low·low, high·low, low·high, high·high) in parallel with half-width copies of itself. Two additions then merge the four results. The recursion ends in a 2x2 leaf made of four AND gates and two half adders. Every width from 2x2 to 16x16 is a separately instantiable module, so each stage can be reused or tested on its own.

Top module: `vm_mult16`

## Requirements
- R1: For every pair of 16-bit unsigned operands, `product` equals their full 32-bit arithmetic product.
- R2: The 2x2 leaf returns the 4-bit product of its 2-bit inputs for all 16 input pairs.
- R3: In the leaf, result bit 0 is x0 AND y0, and result bit 1 is (x1 AND y0) XOR (x0 AND y1).
- R4: In the leaf, result bit 3 is set only for the input pair 3x3, where the result is binary 1001.
- R5: The 4x4 level returns the correct 8-bit product for all 256 input pairs.
- R6: The 8x8 level returns the correct 16-bit product for all 65,536 input pairs.
- R7: The low 8 bits of `product` equal the low 8 bits of the product of the two operands' low bytes.
- R8: When either operand is zero, `product` is zero.
- R9: When one operand is 1, `product` equals the other operand, zero-extended.
- R10: When both operands are 0xFFFF, `product` is 0xFFFE0001, which is the largest value the block can produce.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | Unsigned multiplicand |
| op_b | input | 16 | Unsigned multiplier |
| product | output | 32 | Unsigned full product of op_a and op_b |

## Verification
The hardest case to reach is the one where the middle sum carries into the high·high term at every level at once. This needs operands whose halves are all near full scale, and random operands seldom produce it. The bench therefore first applies every pair drawn from a corner set: zero, one, all ones, both alternating-bit patterns, the top bit alone, and all bits except the top one. After that come random operands. The smaller levels are swept exhaustively. This covers every carry combination in the 8x8 stage, which the 16x16 level reuses four times.

// File: rtl/vedic_pkg.sv
// Shared constants for the recursive crosswise multiplier.
// Assumes operand widths are powers of two and at least 2.
package vedic_pkg;
    parameter int TOP_W  = 16;
    parameter int LEAF_W = 2;
endpackage

// File: rtl/vm_ha.sv
// Half adder: sum and carry of two bits. Purely combinational.
module vm_ha (
    input  logic i0,
    input  logic i1,
    output logic s,
    output logic c
);
    // add two single bits
    always_comb begin
        s = i0 ^ i1;
        c = i0 & i1;
    end
endmodule

// File: rtl/vm_cell2.sv
// 2x2 unsigned leaf multiplier: four AND terms and two half adders.
// Assumes nothing beyond 2-bit unsigned inputs; output is 4 bits.
module vm_cell2 (
    input  logic [1:0] x,
    input  logic [1:0] y,
    output logic [3:0] z
);
    logic t00, t10, t01, t11;
    logic c_lo;

    // partial-product AND terms
    always_comb begin
        t00 = x[0] & y[0];
        t10 = x[1] & y[0];
        t01 = x[0] & y[1];
        t11 = x[1] & y[1];
    end

    // bit 0 passes straight through
    assign z[0] = t00;

    vm_ha u_ha_cross (.i0(t10),  .i1(t01), .s(z[1]), .c(c_lo));
    vm_ha u_ha_top   (.i0(c_lo), .i1(t11), .s(z[2]), .c(z[3]));
endmodule

// File: rtl/vm_combine.sv
// Merges four half-width sub-products into a full product of width 2*W.
// Assumes W is even and each sub-product is W bits wide (H = W/2 per operand half).
module vm_combine #(
    parameter int W = 4
) (
    input  logic [W-1:0]   p_ll,
    input  logic [W-1:0]   p_hl,
    input  logic [W-1:0]   p_lh,
    input  logic [W-1:0]   p_hh,
    output logic [2*W-1:0] z
);
    localparam int H  = W / 2;
    localparam int MW = W + 1;   // middle sum width, never overflows
    localparam int UW = W + H;   // width of the upper result slice

    logic [MW-1:0] mid;
    logic [UW-1:0] upper;

    // sum of the two cross terms and the upper half of low*low
    always_comb mid = MW'(p_ll[W-1:H]) + MW'(p_hl) + MW'(p_lh);

    // final addition with high*high weighted by the full width
    always_comb upper = {p_hh, {H{1'b0}}} + UW'(mid);

    // assemble the result: low bits of low*low pass straight through
    assign z = {upper, p_ll[H-1:0]};
endmodule

// File: rtl/vm_level.sv
// Recursive unsigned W x W multiplier producing 2*W bits.
// Below the leaf width it uses the 2x2 cell; otherwise four half-width
// copies of itself run in parallel and vm_combine merges them.
// Assumes W is a power of two, W >= 2. Purely combinational.
module vm_level #(
    parameter int W = 4
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] z
);
    localparam int H = W / 2;

    generate
        if (W <= vedic_pkg::LEAF_W) begin : g_leaf
            vm_cell2 u_cell (.x(x[1:0]), .y(y[1:0]), .z(z[3:0]));
        end else begin : g_split
            logic [W-1:0] p_ll, p_hl, p_lh, p_hh;

            vm_level #(.W(H)) u_ll (.x(x[H-1:0]), .y(y[H-1:0]), .z(p_ll));
            vm_level #(.W(H)) u_hl (.x(x[W-1:H]), .y(y[H-1:0]), .z(p_hl));
            vm_level #(.W(H)) u_lh (.x(x[H-1:0]), .y(y[W-1:H]), .z(p_lh));
            vm_level #(.W(H)) u_hh (.x(x[W-1:H]), .y(y[W-1:H]), .z(p_hh));

            vm_combine #(.W(W)) u_comb (
                .p_ll(p_ll), .p_hl(p_hl), .p_lh(p_lh), .p_hh(p_hh), .z(z)
            );
        end
    endgenerate
endmodule

// File: rtl/vm_mult16.sv
// Top: 16x16 unsigned multiplier with a 32-bit product, built from the
// recursive crosswise levels. No clock or reset; output follows inputs.
module vm_mult16 (
    input  logic [vedic_pkg::TOP_W-1:0]   op_a,
    input  logic [vedic_pkg::TOP_W-1:0]   op_b,
    output logic [2*vedic_pkg::TOP_W-1:0] product
);
    vm_level #(.W(vedic_pkg::TOP_W)) u_core (.x(op_a), .y(op_b), .z(product));
endmodule

// File: rtl/vm_mult16_chk.sv
// Checker for vm_mult16: relates the product port to the operand ports.
// Immediate assertions, evaluated whenever the combinational values settle.
module vm_mult16_chk (
    input logic [15:0] a,
    input logic [15:0] b,
    input logic [31:0] p
);
    logic [15:0] lo_prod;

    // reference low-byte product for the low-bits property
    always_comb lo_prod = 16'(a[7:0]) * 16'(b[7:0]);

    // properties on the settled product
    always_comb begin
        p_full_product_r1: assert (p == 32'(a) * 32'(b))
            else $error("R1 product mismatch");
        p_low_byte_r7: assert (p[7:0] == lo_prod[7:0])
            else $error("R7 low byte mismatch");
        p_zero_operand_r8: assert (!((a == 16'd0) || (b == 16'd0)) || (p == 32'd0))
            else $error("R8 zero operand gave nonzero product");
        p_unit_operand_r9: assert (!(a == 16'd1) || (p == 32'(b)))
            else $error("R9 unit operand mismatch");
        p_max_bound_r10: assert (p <= 32'hFFFE_0001)
            else $error("R10 product above maximum");
    end
endmodule

bind vm_mult16 vm_mult16_chk i_chk (.a(op_a), .b(op_b), .p(product));

// File: tb/test_vm_mult16.sv
// Bench: exhaustive sweeps of the 2x2, 4x4 and 8x8 levels, corner and
// random operands for the 16x16 top; expected values computed with '*'.
module test_vm_mult16;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    logic [15:0] a16, b16;
    logic [31:0] p16;
    logic [7:0]  a8, b8;
    logic [15:0] p8;
    logic [3:0]  a4, b4;
    logic [7:0]  p4;
    logic [1:0]  a2, b2;
    logic [3:0]  p2;

    always #(CLK_PERIOD/2) clk = ~clk;

    vm_mult16 i_vm_mult16 (.op_a(a16), .op_b(b16), .product(p16));
    vm_level #(.W(8)) i_lvl8 (.x(a8), .y(b8), .z(p8));
    vm_level #(.W(4)) i_lvl4 (.x(a4), .y(b4), .z(p4));
    vm_cell2          i_cell (.x(a2), .y(b2), .z(p2));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        logic [15:0] corners [7];
        logic [31:0] seed;
        corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'hAAAA, 16'h5555, 16'h8000, 16'h7FFF};
        seed = 32'h1234_5678;
        a16 = '0; b16 = '0; a8 = '0; b8 = '0; a4 = '0; b4 = '0; a2 = '0; b2 = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset-state inputs are zero: all products zero (R8)
        chk("R8 idle", 64'(p16), 64'd0);
        chk("R2 idle", 64'(p2), 64'd0);

        // corner operand pairs at the top level
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                @(posedge clk);
                a16 = corners[i]; b16 = corners[j];
                @(negedge clk);
                chk("R1 corner", 64'(p16), 64'(32'(a16) * 32'(b16)));
                if (a16 == 16'd0 || b16 == 16'd0) chk("R8 zero", 64'(p16), 64'd0);
                if (a16 == 16'd1) chk("R9 unit", 64'(p16), 64'(b16));
                if (a16 == 16'hFFFF && b16 == 16'hFFFF)
                    chk("R10 max", 64'(p16), 64'h0000_0000_FFFE_0001);
            end
        end

        // exhaustive small levels alongside random top-level operands
        for (int idx = 0; idx < 65536; idx++) begin
            @(posedge clk);
            {a8, b8} = 16'(idx);
            {a4, b4} = 8'(idx);
            {a2, b2} = 4'(idx);
            seed = seed * 32'd1664525 + 32'd1013904223;
            a16 = seed[31:16];
            seed = seed * 32'd1664525 + 32'd1013904223;
            b16 = seed[31:16];
            @(negedge clk);
            chk("R6 8x8", 64'(p8), 64'(16'(a8) * 16'(b8)));
            if (idx < 256) chk("R5 4x4", 64'(p4), 64'(8'(a4) * 8'(b4)));
            if (idx < 16) begin
                chk("R2 2x2", 64'(p2), 64'(4'(a2) * 4'(b2)));
                chk("R3 bit0", 64'(p2[0]), 64'(a2[0] & b2[0]));
                chk("R3 bit1", 64'(p2[1]), 64'((a2[1] & b2[0]) ^ (a2[0] & b2[1])));
                chk("R4 bit3", 64'(p2[3]), 64'(a2 == 2'd3 && b2 == 2'd3));
            end
            chk("R1 random", 64'(p16), 64'(32'(a16) * 32'(b16)));
            if (idx < 64) chk("R7 low byte", 64'(p16[7:0]), 64'(8'(a16[7:0] * b16[7:0])));
        end
        finished = 1'b1;
        summary();
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule